// File: doc/BRIEF.md
# PWM dimming input decoder

This block turns a digital PWM dimming signal from an external controller into an 8-bit brightness command. The input arrives already cleaned by an analog threshold stage. Inside the block it passes through a two-flop synchronizer and a pulse-width filter. The block then times each period and each high phase in system-clock cycles and converts the ratio into an unsigned duty code. That code is averaged over the last four accepted periods. A fault-handling stage downstream reads the command together with a valid flag, and two diagnostic counters.

Three checks act on the valid flag:

- A programmable period window rejects input frequencies that are too fast or too slow. A policy input chooses whether such a period is dropped silently or marks the input invalid.
- A line that stops toggling is taken as a static full-scale or zero command.
- Period-to-period jitter is counted. A burst of jitter inside a time window withdraws validity.

After validity is lost, a programmable run of good periods is needed before the flag returns.

Top module: `pwm_dim_decoder`

## Requirements
- R1: With a steady input of period P cycles and high time H cycles (H < P, both inside the window), dim_cmd settles to floor(H*256/P). If H >= P the code saturates to 255.
- R2: After synchronization, a high pulse or low gap lasting fewer than cfg_min_pulse cycles creates no edge and does not change the measured timing. Each such rejected pulse increments glitch_count, which saturates.
- R3: A period below cfg_period_min or above cfg_period_max is not decoded. With cfg_oor_invalidate=1 it clears dim_valid. With cfg_oor_invalidate=0 it is ignored: dim_cmd, dim_valid and jitter_count stay unchanged.
- R4: If no edge is seen for more than cfg_stuck_limit cycles, the line is treated as static. dim_cmd becomes 255 for a high line or 0 for a low line, and dim_valid is set to 1.
- R5: dim_cmd is the floor of the mean of the last four decoded duty codes. A single deviating period moves the output by only a quarter of its deviation.
- R6: Each accepted period that differs from the previous accepted period by more than cfg_jit_delta cycles increments jitter_count, which saturates. The comparison restarts after a static-line event.
- R7: Jitter events are counted in a window. The window opens at the first event and lasts cfg_jit_window cycles. When the count in the window exceeds cfg_jit_limit, dim_valid is cleared. Events spread thinly enough that the limit is never exceeded leave dim_valid set.
- R8: Once dim_valid is clear, it is set again only after cfg_good_periods consecutive accepted periods with no window overflow.
- R9: After reset: dim_cmd=0, dim_valid=0, glitch_count=0 and jitter_count=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous PWM dimming input |
| cfg_min_pulse | input | 6 | Minimum accepted pulse or gap, in cycles |
| cfg_period_min | input | 16 | Shortest accepted period, in cycles |
| cfg_period_max | input | 16 | Longest accepted period, in cycles |
| cfg_oor_invalidate | input | 1 | 1: an out-of-window period clears valid; 0: it is ignored |
| cfg_stuck_limit | input | 16 | Idle cycles before the line counts as static |
| cfg_jit_delta | input | 16 | Largest period change not counted as jitter |
| cfg_jit_limit | input | 8 | Jitter events allowed in one window |
| cfg_jit_window | input | 20 | Jitter window length, in cycles |
| cfg_good_periods | input | 4 | Good periods needed to restore valid |
| dim_cmd | output | 8 | Averaged duty command |
| dim_valid | output | 1 | Command is trustworthy |
| glitch_count | output | 16 | Rejected glitches, saturating |
| jitter_count | output | 8 | Jitter events, saturating |

## Verification
Each fault in internal state shows up at the ports within a few periods:

- An off-by-one in the period or high-time counters shifts dim_cmd away from floor(H*256/P) on the first steady burst that follows.
- A stale averaging slot shows as a quarter-step error, four periods after a deviating period.
- A filter that lets short pulses through adds edges. This bends the measured duty and leaves glitch_count short.
- Mistakes in the window, policy or good-run counting show on dim_valid in the same period that decides it, with the static-line timeout as the only longer delay.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;
    localparam int CNT_W   = 16;  // period and timeout counters
    localparam int DUTY_W  = 8;   // duty code width
    localparam int AVG_LOG = 2;   // log2 of averaged periods
    localparam int WIN_W   = 20;  // jitter window timer
    localparam int GLT_W   = 16;  // glitch counter
    localparam int JIT_W   = 8;   // jitter counters
    localparam int MP_W    = 6;   // minimum pulse setting
    localparam int GOOD_W  = 4;   // good-run counter

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DUTY_W-1:0] duty_t;

    typedef struct packed {
        cnt_t period;
        cnt_t high;
    } meas_t;

    function automatic cnt_t abs_diff(input cnt_t a, input cnt_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic logic in_window(input cnt_t p, input cnt_t lo, input cnt_t hi);
        return (p >= lo) && (p <= hi);
    endfunction
endpackage

// File: rtl/pwmdec_filter.sv
module pwmdec_filter
    import pwmdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [MP_W-1:0]  min_pulse,
    output logic             level,
    output logic             rise,
    output logic             fall,
    output logic [GLT_W-1:0] glitch_cnt
);
    logic [1:0]      sync_q;
    logic [MP_W-1:0] run_q;
    logic [MP_W:0]   run_next;
    logic            s_in;

    assign s_in     = sync_q[1];
    assign run_next = {1'b0, run_q} + (MP_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            level      <= 1'b0;
            rise       <= 1'b0;
            fall       <= 1'b0;
            run_q      <= '0;
            glitch_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], din};
            rise   <= 1'b0;
            fall   <= 1'b0;
            if (s_in != level) begin
                if (run_next >= {1'b0, min_pulse}) begin
                    level <= s_in;
                    rise  <= s_in;
                    fall  <= ~s_in;
                    run_q <= '0;
                end else begin
                    run_q <= run_next[MP_W-1:0];
                end
            end else begin
                if (run_q != '0 && glitch_cnt != '1)
                    glitch_cnt <= glitch_cnt + GLT_W'(1);
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/pwmdec_meter.sv
module pwmdec_meter
    import pwmdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level,
    input  logic  rise,
    input  logic  fall,
    input  cnt_t  stuck_limit,
    output logic  samp_vld,
    output meas_t samp,
    output logic  stuck_enter,
    output logic  stuck_lvl
);
    cnt_t per_cnt, hi_len, idle_cnt;
    logic armed, stuck;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt     <= '0;
            hi_len      <= '0;
            idle_cnt    <= '0;
            armed       <= 1'b0;
            stuck       <= 1'b0;
            samp_vld    <= 1'b0;
            samp        <= '0;
            stuck_enter <= 1'b0;
            stuck_lvl   <= 1'b0;
        end else begin
            samp_vld    <= 1'b0;
            stuck_enter <= 1'b0;
            if (rise) begin
                if (armed) begin
                    samp_vld    <= 1'b1;
                    samp.period <= per_cnt;
                    samp.high   <= hi_len;
                end
                armed   <= 1'b1;
                per_cnt <= cnt_t'(1);
            end else if (per_cnt != '1) begin
                per_cnt <= per_cnt + cnt_t'(1);
            end
            if (fall)
                hi_len <= per_cnt;
            if (rise || fall) begin
                idle_cnt <= '0;
                stuck    <= 1'b0;
            end else if (!stuck) begin
                if (idle_cnt >= stuck_limit) begin
                    stuck       <= 1'b1;
                    stuck_enter <= 1'b1;
                    stuck_lvl   <= level;
                    armed       <= 1'b0;
                end else begin
                    idle_cnt <= idle_cnt + cnt_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pwmdec_divider.sv
module pwmdec_divider
    import pwmdec_pkg::*;
#(
    parameter int NW = CNT_W,
    parameter int QW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic          done,
    output logic [QW-1:0] quo
);
    localparam int SW = $clog2(QW + 1);

    logic [NW-1:0] rem_q, den_q;
    logic [NW:0]   shifted, diff;
    logic [SW-1:0] steps;
    logic          busy;

    assign shifted = {rem_q, 1'b0};
    assign diff    = shifted - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            den_q <= '0;
            steps <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
            quo   <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (!diff[NW]) begin
                    rem_q <= diff[NW-1:0];
                    quo   <= {quo[QW-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[NW-1:0];
                    quo   <= {quo[QW-2:0], 1'b0};
                end
                steps <= steps - SW'(1);
                if (steps == SW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (start) begin
                if (num >= den) begin
                    quo  <= '1;
                    done <= 1'b1;
                end else begin
                    rem_q <= num;
                    den_q <= den;
                    quo   <= '0;
                    steps <= SW'(QW);
                    busy  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pwm_dim_decoder.sv
module pwm_dim_decoder
    import pwmdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_in,
    input  logic [MP_W-1:0]   cfg_min_pulse,
    input  logic [CNT_W-1:0]  cfg_period_min,
    input  logic [CNT_W-1:0]  cfg_period_max,
    input  logic              cfg_oor_invalidate,
    input  logic [CNT_W-1:0]  cfg_stuck_limit,
    input  logic [CNT_W-1:0]  cfg_jit_delta,
    input  logic [JIT_W-1:0]  cfg_jit_limit,
    input  logic [WIN_W-1:0]  cfg_jit_window,
    input  logic [GOOD_W-1:0] cfg_good_periods,
    output logic [DUTY_W-1:0] dim_cmd,
    output logic              dim_valid,
    output logic [GLT_W-1:0]  glitch_count,
    output logic [JIT_W-1:0]  jitter_count
);
    localparam int AVG_N = 1 << AVG_LOG;
    localparam int SUM_W = DUTY_W + AVG_LOG;

    logic  level, rise, fall;
    logic  samp_vld, stuck_enter, stuck_lvl, div_done;
    meas_t samp;
    cnt_t  samp_period;
    duty_t div_q;

    pwmdec_filter u_filter (
        .clk(clk), .rst(rst), .din(pwm_in), .min_pulse(cfg_min_pulse),
        .level(level), .rise(rise), .fall(fall), .glitch_cnt(glitch_count)
    );

    pwmdec_meter u_meter (
        .clk(clk), .rst(rst), .level(level), .rise(rise), .fall(fall),
        .stuck_limit(cfg_stuck_limit), .samp_vld(samp_vld), .samp(samp),
        .stuck_enter(stuck_enter), .stuck_lvl(stuck_lvl)
    );

    assign samp_period = samp.period;

    logic in_win, accept;
    assign in_win = in_window(samp_period, cfg_period_min, cfg_period_max);
    assign accept = samp_vld && in_win;

    pwmdec_divider #(.NW(CNT_W), .QW(DUTY_W)) u_div (
        .clk(clk), .rst(rst), .start(accept), .num(samp.high),
        .den(samp_period), .done(div_done), .quo(div_q)
    );

    // jitter detection and windowed event count
    cnt_t              prev_per;
    logic              prev_ok;
    logic [JIT_W-1:0]  win_evt, evt_next;
    logic [WIN_W-1:0]  win_tmr;
    logic              jit_hit, jit_over;

    assign jit_hit  = accept && prev_ok && (abs_diff(samp_period, prev_per) > cfg_jit_delta);
    assign evt_next = (jit_hit && win_evt != '1) ? win_evt + JIT_W'(1) : win_evt;
    assign jit_over = jit_hit && (evt_next > cfg_jit_limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_per     <= '0;
            prev_ok      <= 1'b0;
            win_evt      <= '0;
            win_tmr      <= '0;
            jitter_count <= '0;
        end else begin
            if (stuck_enter) begin
                prev_ok <= 1'b0;
            end else if (accept) begin
                prev_per <= samp_period;
                prev_ok  <= 1'b1;
            end
            if (jit_hit && jitter_count != '1)
                jitter_count <= jitter_count + JIT_W'(1);
            if (win_evt == '0) begin
                win_tmr <= '0;
                win_evt <= evt_next;
            end else if (win_tmr >= cfg_jit_window) begin
                win_evt <= '0;
                win_tmr <= '0;
            end else begin
                win_tmr <= win_tmr + WIN_W'(1);
                win_evt <= evt_next;
            end
        end
    end

    // validity and good-run tracking
    logic [GOOD_W-1:0] good_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            dim_valid <= 1'b0;
            good_run  <= '0;
        end else if (stuck_enter) begin
            dim_valid <= 1'b1;
            good_run  <= '0;
        end else if (samp_vld) begin
            if (!in_win) begin
                if (cfg_oor_invalidate) begin
                    dim_valid <= 1'b0;
                    good_run  <= '0;
                end
            end else if (jit_over) begin
                dim_valid <= 1'b0;
                good_run  <= '0;
            end else begin
                if (good_run != '1)
                    good_run <= good_run + GOOD_W'(1);
                if ({1'b0, good_run} + (GOOD_W+1)'(1) >= {1'b0, cfg_good_periods})
                    dim_valid <= 1'b1;
            end
        end
    end

    // duty history and average
    duty_t hist_q [AVG_N];
    logic [SUM_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < AVG_N; i++) hist_q[i] <= '0;
        end else if (stuck_enter) begin
            for (int i = 0; i < AVG_N; i++) hist_q[i] <= {DUTY_W{stuck_lvl}};
        end else if (div_done) begin
            hist_q[0] <= div_q;
            for (int i = 1; i < AVG_N; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < AVG_N; i++) sum = sum + SUM_W'(hist_q[i]);
    end

    assign dim_cmd = DUTY_W'(sum >> AVG_LOG);
endmodule

// File: rtl/pwmdec_checker.sv
module pwmdec_checker
    import pwmdec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cfg_period_min,
    input logic [CNT_W-1:0]  cfg_period_max,
    input logic              cfg_oor_invalidate,
    input logic              samp_vld,
    input logic [CNT_W-1:0]  samp_period,
    input logic              stuck_enter,
    input logic              stuck_lvl,
    input logic              div_done,
    input logic              jit_over,
    input logic [DUTY_W-1:0] dim_cmd,
    input logic              dim_valid,
    input logic [GLT_W-1:0]  glitch_count,
    input logic [JIT_W-1:0]  jitter_count
);
    logic oor;
    assign oor = (samp_period < cfg_period_min) || (samp_period > cfg_period_max);

    AST_GLITCH_NONDECR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> glitch_count >= $past(glitch_count)); // R2

    AST_OOR_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        samp_vld && oor && cfg_oor_invalidate && !stuck_enter |=> !dim_valid); // R3

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        samp_vld && oor && !cfg_oor_invalidate && !stuck_enter && !div_done
        |=> $stable(dim_cmd) && $stable(dim_valid)); // R3

    AST_STUCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        stuck_enter && stuck_lvl |=> dim_cmd == '1 && dim_valid); // R4

    AST_STUCK_LOW: assert property (@(posedge clk) disable iff (rst)
        stuck_enter && !stuck_lvl |=> dim_cmd == '0 && dim_valid); // R4

    AST_JITTER_NONDECR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> jitter_count >= $past(jitter_count)); // R6

    AST_JITTER_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        jit_over && !stuck_enter |=> !dim_valid); // R7

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(dim_valid) |-> $past(samp_vld || stuck_enter)); // R8
endmodule

bind pwm_dim_decoder pwmdec_checker chk_i (
    .clk(clk), .rst(rst),
    .cfg_period_min(cfg_period_min), .cfg_period_max(cfg_period_max),
    .cfg_oor_invalidate(cfg_oor_invalidate),
    .samp_vld(samp_vld), .samp_period(samp_period),
    .stuck_enter(stuck_enter), .stuck_lvl(stuck_lvl),
    .div_done(div_done), .jit_over(jit_over),
    .dim_cmd(dim_cmd), .dim_valid(dim_valid),
    .glitch_count(glitch_count), .jitter_count(jitter_count)
);

// File: tb/pwm_dim_decoder_tb_top.sv
module pwm_dim_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwm_in = 1'b0;
    logic [5:0]  cfg_min_pulse = 6'd4;
    logic [15:0] cfg_period_min = 16'd50;
    logic [15:0] cfg_period_max = 16'd1000;
    logic        cfg_oor_invalidate = 1'b1;
    logic [15:0] cfg_stuck_limit = 16'd1200;
    logic [15:0] cfg_jit_delta = 16'd20;
    logic [7:0]  cfg_jit_limit = 8'd3;
    logic [19:0] cfg_jit_window = 20'd1000;
    logic [3:0]  cfg_good_periods = 4'd3;
    logic [7:0]  dim_cmd;
    logic        dim_valid;
    logic [15:0] glitch_count;
    logic [7:0]  jitter_count;

    int n_checks = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dim_decoder dut_i (
        .clk(clk), .rst(rst), .pwm_in(pwm_in),
        .cfg_min_pulse(cfg_min_pulse), .cfg_period_min(cfg_period_min),
        .cfg_period_max(cfg_period_max), .cfg_oor_invalidate(cfg_oor_invalidate),
        .cfg_stuck_limit(cfg_stuck_limit), .cfg_jit_delta(cfg_jit_delta),
        .cfg_jit_limit(cfg_jit_limit), .cfg_jit_window(cfg_jit_window),
        .cfg_good_periods(cfg_good_periods), .dim_cmd(dim_cmd),
        .dim_valid(dim_valid), .glitch_count(glitch_count),
        .jitter_count(jitter_count)
    );

    function automatic int exp_duty(input int p, input int h);
        return (h >= p) ? 255 : (h * 256) / p;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic period(input int p, input int h);
        pwm_in = 1'b1; wait_cyc(h);
        pwm_in = 1'b0; wait_cyc(p - h);
    endtask

    task automatic burst(input int p, input int h, input int n);
        for (int i = 0; i < n; i++) period(p, h);
    endtask

    task automatic jitter_burst(input int n);
        for (int i = 0; i < n; i++) period((i % 2 == 0) ? 200 : 240, 100);
    endtask

    task automatic idle_low();
        pwm_in = 1'b0; wait_cyc(1500);
    endtask

    initial begin
        wait_cyc(WATCHDOG);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        int seed_init;
        int g0, j0;
        seed_init = $urandom(32'd1234);
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R9 reset state
        chk("R9 cmd", dim_cmd, 0);
        chk("R9 valid", dim_valid, 0);
        chk("R9 glitch", glitch_count, 0);
        chk("R9 jitter", jitter_count, 0);

        // R8: two samples not enough, third restores valid
        burst(200, 100, 3);
        chk("R8 valid after 2 periods", dim_valid, 0);
        chk("R5 partial average", dim_cmd, 64);
        burst(200, 100, 1);
        chk("R8 valid after 3 periods", dim_valid, 1);
        chk("R5 three of four", dim_cmd, 96);
        burst(200, 100, 2);
        chk("R1 duty 100/200", dim_cmd, exp_duty(200, 100));

        // R5 single deviating period
        period(200, 150);
        burst(200, 100, 1);
        chk("R5 deviant diluted", dim_cmd, (exp_duty(200, 150) + 3 * 128) / 4);
        burst(200, 100, 4);
        chk("R5 deviant flushed", dim_cmd, 128);

        // R4 static lines
        pwm_in = 1'b1; wait_cyc(1500);
        chk("R4 stuck high cmd", dim_cmd, 255);
        chk("R4 stuck high valid", dim_valid, 1);
        idle_low();
        chk("R4 stuck low cmd", dim_cmd, 0);
        chk("R4 stuck low valid", dim_valid, 1);
        chk("R6 no jitter on steady input", jitter_count, 0);

        // R1 random duty patterns
        for (int k = 0; k < 6; k++) begin
            int p, h;
            p = $urandom_range(600, 100);
            h = $urandom_range(p - 10, 10);
            burst(p, h, 6);
            chk("R1 random duty", dim_cmd, exp_duty(p, h));
            chk("R1 random valid", dim_valid, 1);
            idle_low();
            chk("R4 back to zero", dim_cmd, 0);
        end

        // R2 glitches in high and low phases
        g0 = glitch_count;
        for (int i = 0; i < 6; i++) begin
            pwm_in = 1'b1; wait_cyc(40);
            pwm_in = 1'b0; wait_cyc(3);
            pwm_in = 1'b1; wait_cyc(57);
            pwm_in = 1'b0; wait_cyc(50);
            pwm_in = 1'b1; wait_cyc(2);
            pwm_in = 1'b0; wait_cyc(48);
        end
        chk("R2 glitch count", glitch_count, g0 + 12);
        chk("R2 duty unaffected", dim_cmd, 128);
        idle_low();

        // R3 ignore policy
        j0 = jitter_count;
        cfg_oor_invalidate = 1'b0;
        burst(40, 20, 6);
        chk("R3 ignored cmd", dim_cmd, 0);
        chk("R3 ignored valid", dim_valid, 1);
        chk("R3 ignored jitter", jitter_count, j0);
        // R3 invalidate policy, then R8 recovery
        cfg_oor_invalidate = 1'b1;
        burst(40, 20, 4);
        chk("R3 flagged invalid", dim_valid, 0);
        burst(200, 100, 3);
        chk("R8 still invalid after 2", dim_valid, 0);
        burst(200, 100, 1);
        chk("R8 valid after 3", dim_valid, 1);
        idle_low();

        // R6/R7 jitter: short window never overflows
        j0 = jitter_count;
        cfg_jit_window = 20'd500;
        jitter_burst(6);
        chk("R6 jitter events", jitter_count, j0 + 4);
        chk("R7 short window keeps valid", dim_valid, 1);
        idle_low();
        // long window overflows on the fourth event
        j0 = jitter_count;
        cfg_jit_window = 20'd1000;
        jitter_burst(6);
        chk("R6 jitter events 2", jitter_count, j0 + 4);
        chk("R7 window overflow clears valid", dim_valid, 0);
        idle_low();

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule